// File: doc/BRIEF.md
# Ripple Bit-Slice Four-Function ALU

This block is a small arithmetic logic unit. It is built from a row of identical one-bit cells, and each cell handles one bit position of the two operands. A two-bit operation code selects one of four results: the bitwise AND of the operands, their bitwise OR, the bitwise inverse of the second operand, or their arithmetic sum. Every cell decodes the operation code locally into four one-hot enables. Each cell passes its carry to the next more significant cell, so the sum ripples from the least significant bit upward.

The datapath has no clock and no storage. The result and the carry out follow the operands, the operation code and the carry in directly. The external carry in enters the lowest cell. The carry out of the highest cell is the carry out of the block. For the three logic operations the carry out is held at zero, and the carry in has no effect.

Top module: `alu_slice_chain`

## Requirements
- R1: The operation code is decoded into exactly one active enable, so each code value selects exactly one of the four operations.
- R2: Code 2'b00 gives result = A AND B, bit by bit, with carry out 0.
- R3: Code 2'b01 gives result = A OR B, bit by bit, with carry out 0.
- R4: Code 2'b10 gives result = NOT B, bit by bit, with carry out 0, and the value of A has no effect on the result.
- R5: Code 2'b11 gives {carry out, result} = A + B + carry in, as a WIDTH+1 bit unsigned sum.
- R6: For codes 2'b00, 2'b01 and 2'b10 the carry in has no effect on the result, and the carry out is 0.
- R7: The carry ripples across every slice. With A = 0xFF, B = 0x01 and carry in = 1 under ADD, the result is 0x01 and the carry out is 1. With A = 0xFF, B = 0x00 and carry in = 1, the result is 0x00 and the carry out is 1.
- R8: The outputs settle from a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_opnd | input | WIDTH (8) | First operand |
| b_opnd | input | WIDTH (8) | Second operand |
| fn_sel | input | 2 | Operation code: 00 AND, 01 OR, 10 NOT B, 11 ADD |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | WIDTH (8) | Operation result |
| carry_out | output | 1 | Carry out of the most significant slice; 0 for logic operations |

## Verification
Whenever the inputs change, the embedded assertions check three things. Each slice's decoded enables must be one-hot. No slice may raise a carry under a logic operation. Under ADD, the top-level carry and result must together equal the arithmetic sum of the ports. The bench scenarios alone show the rest. For NOT B and for the other logic operations, the A operand and the carry in truly leave the result untouched. The code values map to the intended operations. The ripple through all eight slices holds at the worst-case boundary operands. The bench sweeps every operand pair, every code and both carry-in values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_INV = 2'b10,
        OP_ADD = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic use_and;
        logic use_or;
        logic use_inv;
        logic use_add;
    } op_enables_t;

    localparam int unsigned NUM_OPS = 4;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [1:0]  op_code,
    output op_enables_t enables
);

    alu_op_e op_q;

    always_comb begin
        op_q    = alu_op_e'(op_code);
        enables = '0;
        unique case (op_q)
            OP_AND:  enables.use_and = 1'b1;
            OP_OR:   enables.use_or  = 1'b1;
            OP_INV:  enables.use_inv = 1'b1;
            OP_ADD:  enables.use_add = 1'b1;
            default: enables = '0;
        endcase
    end

    always_comb begin
        // R1
        onehot_enable_chk: assert ($countones(enables) == 1)
            else $error("decoder enables not one-hot: %b", enables);
    end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic [1:0] op_code,
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       c_in,
    output logic       r_bit,
    output logic       c_out
);

    op_enables_t en;
    logic        half_sum;
    logic        full_sum;
    logic        carry_gen;

    alu_op_decoder i_dec (
        .op_code (op_code),
        .enables (en)
    );

    always_comb begin
        half_sum  = a_bit ^ b_bit;
        full_sum  = half_sum ^ c_in;
        carry_gen = (a_bit & b_bit) | (c_in & half_sum);
    end

    always_comb begin
        r_bit = (en.use_and & (a_bit & b_bit))
              | (en.use_or  & (a_bit | b_bit))
              | (en.use_inv & ~b_bit)
              | (en.use_add & full_sum);
        c_out = en.use_add & carry_gen;
    end

    always_comb begin
        // R6
        cell_logic_carry_chk: assert (en.use_add || !c_out)
            else $error("cell raised carry under logic op");
        // R4
        cell_inv_chk: assert (!en.use_inv || (r_bit == !b_bit))
            else $error("cell inverse mismatch");
    end

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_opnd,
    input  logic [WIDTH-1:0] b_opnd,
    input  logic [1:0]       fn_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int unsigned CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] carry_chain;

    assign carry_chain[0] = carry_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        alu_bit_cell i_cell (
            .op_code (fn_sel),
            .a_bit   (a_opnd[gi]),
            .b_bit   (b_opnd[gi]),
            .c_in    (carry_chain[gi]),
            .r_bit   (result[gi]),
            .c_out   (carry_chain[gi+1])
        );
    end

    assign carry_out = carry_chain[WIDTH];

    logic [WIDTH:0] ref_sum;

    always_comb begin
        ref_sum = {1'b0, a_opnd} + {1'b0, b_opnd} + {{WIDTH{1'b0}}, carry_in};
        // R5
        add_sum_chk: assert ((fn_sel != OP_ADD) || ({carry_out, result} == ref_sum))
            else $error("ripple sum mismatch");
        // R6
        logic_cout_chk: assert ((fn_sel == OP_ADD) || !carry_out)
            else $error("carry out set under logic op");
    end

endmodule

// File: tb/test_alu_slice_chain.sv
module test_alu_slice_chain;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_opnd = '0;
    logic [W-1:0] b_opnd = '0;
    logic [1:0]   fn_sel = 2'b00;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu_slice_chain #(.WIDTH(W)) i_alu_slice_chain (
        .a_opnd    (a_opnd),
        .b_opnd    (b_opnd),
        .fn_sel    (fn_sel),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h fn=%b cin=%b actual=%h expected=%h",
                     req, a_opnd, b_opnd, fn_sel, carry_in, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [1:0] f, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic c);
        case (f)
            2'b00:   return {1'b0, a & b};
            2'b01:   return {1'b0, a | b};
            2'b10:   return {1'b0, ~b};
            default: return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        endcase
    endfunction

    task automatic apply(input logic [1:0] f, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c);
        fn_sel = f; a_opnd = a; b_opnd = b; carry_in = c;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R2 state out of reset with all inputs zero
        #1 chk("R2 reset", {carry_out, result}, 9'h000);

        // R1 each code picks one distinct operation
        apply(2'b00, 8'hF0, 8'hCC, 1'b0); chk("R1 and", {carry_out, result}, 9'h0C0);
        apply(2'b01, 8'hF0, 8'hCC, 1'b0); chk("R1 or",  {carry_out, result}, 9'h0FC);
        apply(2'b10, 8'hF0, 8'hCC, 1'b0); chk("R1 inv", {carry_out, result}, 9'h033);
        apply(2'b11, 8'hF0, 8'hCC, 1'b0); chk("R1 add", {carry_out, result}, 9'h1BC);

        // R7 ripple corners
        apply(2'b11, 8'hFF, 8'h01, 1'b1); chk("R7 ff+01+1", {carry_out, result}, 9'h101);
        apply(2'b11, 8'hFF, 8'h00, 1'b1); chk("R7 ff+00+1", {carry_out, result}, 9'h100);
        apply(2'b11, 8'hFF, 8'hFF, 1'b1); chk("R7 ff+ff+1", {carry_out, result}, 9'h1FF);
        apply(2'b11, 8'h00, 8'h00, 1'b0); chk("R7 zero",    {carry_out, result}, 9'h000);

        // R8 output follows input change with no clock edge in between
        @(negedge clk);
        fn_sel = 2'b01; a_opnd = 8'h0F; b_opnd = 8'h30; carry_in = 1'b0;
        #1 chk("R8 settle", {carry_out, result}, 9'h03F);
        a_opnd = 8'hC0;
        #1 chk("R8 resettle", {carry_out, result}, 9'h0F0);

        // R4 A ignored under NOT B, R6 carry in ignored for logic codes
        for (int a = 0; a < 256; a++) begin
            apply(2'b10, a[W-1:0], 8'h5A, a[0]);
            chk("R4 a ignored", {carry_out, result}, 9'h0A5);
        end
        for (int f = 0; f < 3; f++) begin
            apply(f[1:0], 8'h96, 8'h3C, 1'b1);
            chk("R6 cin ignored", {carry_out, result}, model(f[1:0], 8'h96, 8'h3C, 1'b0));
        end

        // R2 R3 R4 R5 exhaustive sweep
        for (int f = 0; f < 4; f++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(f[1:0], a[W-1:0], b[W-1:0], c[0]);
                        case (f)
                            0: chk("R2 sweep", {carry_out, result}, model(2'b00, a[W-1:0], b[W-1:0], c[0]));
                            1: chk("R3 sweep", {carry_out, result}, model(2'b01, a[W-1:0], b[W-1:0], c[0]));
                            2: chk("R4 sweep", {carry_out, result}, model(2'b10, a[W-1:0], b[W-1:0], c[0]));
                            default: chk("R5 sweep", {carry_out, result}, model(2'b11, a[W-1:0], b[W-1:0], c[0]));
                        endcase
                    end
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule